// File: doc/BRIEF.md
# Buffered Resource Slot Tracker

This block keeps the dispatch-side view of a set of execution resources. Each resource is given a signed capacity at elaboration: -1 means no slot limit, 0 means a dispatch hazard that is held from dispatch until execution frees it, 1 means an in-order unit, and a larger value means a buffered unit acting as its own reservation station. For every buffered resource the block keeps a free-slot counter. For every hazard resource it keeps a held flag.

A dispatch stage presents a bitmask of the resources an operation needs. In the same cycle it gets one combined status code for the whole mask. When it asserts the dispatch strobe and the status is open, the block takes one slot from every named buffered resource and holds every named hazard resource. Separate release and unhold masks return slots and clear holds as operations leave the machine. An error output flags refused dispatches and releases that would overflow a counter.

Top module: `slot_tracker`

## Requirements
- R1: After reset every buffered resource's free count equals its capacity, resources with capacity -1 or 0 show a free count of 0, no hazard is held, and the status for any mask is open.
- R2: The status encoding is 0 = open, 1 = full, 2 = held. A buffered resource reports full when its free count is 0 and open otherwise.
- R3: A dispatch that commits removes exactly one slot from each buffered resource in the mask. The result is visible on the free-slot output in the next cycle.
- R4: A committed dispatch holds every capacity-0 resource in the mask, which then reports held (2). The status returns to open the cycle after its bit is set on the unhold mask.
- R5: A release adds one slot to a buffered resource. When the count already equals the capacity, the release leaves the count unchanged and raises err in that cycle.
- R6: A resource with capacity -1 always reports open, however many dispatches name it.
- R7: The combined status is the status of the lowest-index resource in the mask that is not open. It is open when every named resource is open, including when the mask is zero.
- R8: When the dispatch strobe is asserted while the combined status is not open, err is raised in that cycle. No counter or hold changes.
- R9: When a committed dispatch and a release name the same buffered resource in one cycle, its count is left unchanged.
- R10: A release naming a capacity-0 or capacity -1 resource has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch strobe; commits when status is open |
| disp_mask | input | NUM_RES | Resources queried and used by the dispatch |
| rel_mask | input | NUM_RES | One slot returned to each named buffered resource |
| unhold_mask | input | NUM_RES | Clears the hold on each named hazard resource |
| status | output | 2 | Combined status of disp_mask (0 open, 1 full, 2 held) |
| err | output | 1 | Refused dispatch or overflowing release this cycle |
| free_slots | output | NUM_RES*SLOT_W | Free count per resource, resource i at bits [i*SLOT_W +: SLOT_W] |

## Verification
Status and err are combinational on the current state and the inputs of the same cycle. The bench therefore samples them shortly after driving a step, before the next rising edge. Counter and hold updates land at that edge, so their effect on free_slots and on status shows up only in the step after the stimulus. A reference model queues one expected item per step, holding the status, the err value and the packed free-slot vector. A monitor pops and compares that item in the same sampling window, so every expectation is tied to the cycle in which it falls due.

// File: rtl/slot_tracker_pkg.sv
package slot_tracker_pkg;
   typedef enum logic [1:0] {
      ST_OPEN = 2'd0,
      ST_FULL = 2'd1,
      ST_HELD = 2'd2
   } slot_st_e;
endpackage

// File: rtl/rs_slot_cell.sv
module rs_slot_cell
   import slot_tracker_pkg::*;
#(
   parameter int SIZE   = 2,
   parameter int SLOT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              give,
   input  logic              clear,
   output slot_st_e          st,
   output logic [SLOT_W-1:0] free,
   output logic              ovf
);
   generate
      if (SIZE > 0) begin : g_buffered
         localparam logic [SLOT_W-1:0] CAP = SLOT_W'(SIZE);
         logic [SLOT_W-1:0] cnt;
         logic              unused_clear;
         assign unused_clear = clear;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= CAP;
            else if (take && give)
               cnt <= cnt;
            else if (take && cnt != '0)
               cnt <= cnt - 1'b1;
            else if (give && cnt != CAP)
               cnt <= cnt + 1'b1;
         end

         assign st   = (cnt == '0) ? ST_FULL : ST_OPEN;
         assign free = cnt;
         assign ovf  = give && !take && (cnt == CAP);

         a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CAP);
         a_r3_take_dec: assert property (@(posedge clk) disable iff (!rst_n)
            take && !give && cnt != '0 |=> cnt == $past(cnt) - 1'b1);
         a_r9_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            take && give |=> $stable(cnt));
         a_r5_give_inc: assert property (@(posedge clk) disable iff (!rst_n)
            give && !take && cnt != CAP |=> cnt == $past(cnt) + 1'b1);
      end else if (SIZE == 0) begin : g_hazard
         logic held;
         logic unused_give;
         assign unused_give = give;

         always_ff @(posedge clk) begin
            if (!rst_n)
               held <= 1'b0;
            else
               held <= (held && !clear) || take;
         end

         assign st   = held ? ST_HELD : ST_OPEN;
         assign free = '0;
         assign ovf  = 1'b0;

         a_r4_hazard_set: assert property (@(posedge clk) disable iff (!rst_n)
            take |=> st == ST_HELD);
         a_r4_hazard_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clear && !take |=> st == ST_OPEN);
      end else begin : g_unbounded
         logic unused_in;
         assign unused_in = ^{clk, rst_n, take, give, clear};
         assign st   = ST_OPEN;
         assign free = '0;
         assign ovf  = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rs_status_merge.sv
module rs_status_merge
   import slot_tracker_pkg::*;
#(
   parameter int NUM_RES = 4
) (
   input  logic [NUM_RES-1:0]   mask,
   input  logic [2*NUM_RES-1:0] st_flat,
   output slot_st_e             status
);
   always_comb begin
      status = ST_OPEN;
      for (int i = NUM_RES - 1; i >= 0; i--) begin
         if (mask[i] && slot_st_e'(st_flat[2*i +: 2]) != ST_OPEN)
            status = slot_st_e'(st_flat[2*i +: 2]);
      end
   end
endmodule

// File: rtl/slot_tracker.sv
module slot_tracker
   import slot_tracker_pkg::*;
#(
   parameter int NUM_RES           = 4,
   parameter int SLOT_W            = 4,
   parameter int BUF_SIZE [NUM_RES] = '{3, 1, 0, -1}
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      disp_valid,
   input  logic [NUM_RES-1:0]        disp_mask,
   input  logic [NUM_RES-1:0]        rel_mask,
   input  logic [NUM_RES-1:0]        unhold_mask,
   output logic [1:0]                status,
   output logic                      err,
   output logic [NUM_RES*SLOT_W-1:0] free_slots
);
   localparam int ST_BITS = 2 * NUM_RES;

   if (NUM_RES < 1) begin : g_chk_n
      $error("slot_tracker: NUM_RES must be at least 1");
   end
   if (SLOT_W < 1) begin : g_chk_w
      $error("slot_tracker: SLOT_W must be at least 1");
   end

   logic [ST_BITS-1:0] st_flat;
   logic [NUM_RES-1:0] ovf;
   logic [NUM_RES-1:0] take;
   slot_st_e           combined;
   logic               commit;

   assign commit = disp_valid && (combined == ST_OPEN);
   assign take   = commit ? disp_mask : '0;

   genvar i;
   generate
      for (i = 0; i < NUM_RES; i++) begin : g_res
         if (BUF_SIZE[i] < -1 || BUF_SIZE[i] >= (1 << SLOT_W)) begin : g_chk
            $error("slot_tracker: capacity out of range for SLOT_W");
         end
         slot_st_e cell_st;
         rs_slot_cell #(.SIZE(BUF_SIZE[i]), .SLOT_W(SLOT_W)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take[i]),
            .give  (rel_mask[i]),
            .clear (unhold_mask[i]),
            .st    (cell_st),
            .free  (free_slots[i*SLOT_W +: SLOT_W]),
            .ovf   (ovf[i])
         );
         assign st_flat[2*i +: 2] = cell_st;
      end
   endgenerate

   rs_status_merge #(.NUM_RES(NUM_RES)) u_merge (
      .mask    (disp_mask),
      .st_flat (st_flat),
      .status  (combined)
   );

   assign status = combined;
   assign err    = (disp_valid && !commit) || (|ovf);

   a_r7_zero_mask_open: assert property (@(posedge clk) disable iff (!rst_n)
      disp_mask == '0 |-> status == ST_OPEN);
   a_r8_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && status != ST_OPEN && rel_mask == '0 && unhold_mask == '0
      |=> $stable(free_slots));
   a_r8_refused_err: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && status != ST_OPEN |-> err);
endmodule

// File: tb/tb_slot_tracker.sv
`timescale 1ns/1ps
module tb_slot_tracker;
   localparam int N = 4;
   localparam int W = 4;
   localparam int CAP [N] = '{3, 1, 0, -1};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         disp_valid = 1'b0;
   logic [N-1:0] disp_mask = '0;
   logic [N-1:0] rel_mask = '0;
   logic [N-1:0] unhold_mask = '0;
   logic [1:0]   status;
   logic         err;
   logic [N*W-1:0] free_slots;

   always #4 clk = ~clk;

   slot_tracker dut (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_mask(disp_mask),
      .rel_mask(rel_mask), .unhold_mask(unhold_mask), .status(status),
      .err(err), .free_slots(free_slots)
   );

   typedef struct {
      logic [1:0]     st;
      logic           er;
      logic [N*W-1:0] fr;
      string          tag;
   } exp_t;

   exp_t q[$];
   int   total = 0;
   int   fails = 0;
   int   m_cnt [N];
   bit   m_held [N];

   function automatic logic [1:0] m_status(input logic [N-1:0] m);
      for (int i = 0; i < N; i++) begin
         if (m[i]) begin
            if (CAP[i] == 0 && m_held[i]) return 2'd2;
            if (CAP[i] > 0 && m_cnt[i] == 0) return 2'd1;
         end
      end
      return 2'd0;
   endfunction

   function automatic logic [N*W-1:0] m_free();
      logic [N*W-1:0] f = '0;
      for (int i = 0; i < N; i++) f[i*W +: W] = W'(m_cnt[i]);
      return f;
   endfunction

   task automatic step(input logic v, input logic [N-1:0] m, input logic [N-1:0] r,
                       input logic [N-1:0] u, input string tag);
      exp_t e;
      logic commit, ov;
      @(negedge clk);
      disp_valid = v; disp_mask = m; rel_mask = r; unhold_mask = u;
      e.st  = m_status(m);
      commit = v && (e.st == 2'd0);
      ov = 1'b0;
      for (int i = 0; i < N; i++)
         if (r[i] && CAP[i] > 0 && m_cnt[i] == CAP[i] && !(commit && m[i])) ov = 1'b1;
      e.er  = (v && !commit) || ov;
      e.fr  = m_free();
      e.tag = tag;
      q.push_back(e);
      for (int i = 0; i < N; i++) begin
         logic tk;
         tk = commit && m[i];
         if (CAP[i] > 0) begin
            if (tk && r[i]) m_cnt[i] = m_cnt[i];
            else if (tk && m_cnt[i] > 0) m_cnt[i]--;
            else if (r[i] && m_cnt[i] < CAP[i]) m_cnt[i]++;
         end else if (CAP[i] == 0) begin
            m_held[i] = (m_held[i] && !u[i]) || tk;
         end
      end
   endtask

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         cmp(e.tag, "status", int'(status), int'(e.st));
         cmp(e.tag, "err", int'(err), int'(e.er));
         cmp(e.tag, "free_slots", int'(free_slots), int'(e.fr));
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_cnt[i] = (CAP[i] > 0) ? CAP[i] : 0;
         m_held[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state, checked also against a fixed value
      step(0, 4'b1111, 4'b0000, 4'b0000, "R1 reset");
      @(negedge clk); #2;
      cmp("R1 reset fixed", "free_slots", int'(free_slots), 16'h0013);
      step(1, 4'b0011, 4'b0000, 4'b0000, "R3 dispatch two buffered");
      step(0, 4'b0010, 4'b0000, 4'b0000, "R2 in-order unit full");
      step(1, 4'b0010, 4'b0000, 4'b0000, "R8 refused when full");
      step(0, 4'b0011, 4'b0000, 4'b0000, "R7 lowest non-open");
      step(1, 4'b0100, 4'b0000, 4'b0000, "R4 hold hazard");
      step(0, 4'b0100, 4'b0000, 4'b0000, "R4 hazard reports held");
      step(0, 4'b0110, 4'b0000, 4'b0000, "R7 full before held");
      step(1, 4'b0101, 4'b0000, 4'b0000, "R8 refused when held");
      step(0, 4'b0000, 4'b0010, 4'b0000, "R5 release in-order");
      step(0, 4'b0000, 4'b0010, 4'b0000, "R5 release overflow");
      step(0, 4'b0000, 4'b1100, 4'b0000, "R10 release on hazard and unbounded");
      step(0, 4'b0100, 4'b0000, 4'b0100, "R4 unhold");
      step(0, 4'b0100, 4'b0000, 4'b0000, "R4 open after unhold");
      step(1, 4'b0001, 4'b0001, 4'b0000, "R9 take and give same cycle");
      step(1, 4'b1000, 4'b0000, 4'b0000, "R6 unbounded dispatch");
      step(1, 4'b1000, 4'b0000, 4'b0000, "R6 unbounded dispatch again");
      step(1, 4'b1001, 4'b0000, 4'b0000, "R3 drain one");
      step(1, 4'b0001, 4'b0000, 4'b0000, "R3 drain two");
      step(0, 4'b1001, 4'b0000, 4'b0000, "R2 buffered empty full");
      step(0, 4'b0000, 4'b0000, 4'b0000, "R7 zero mask open");
      step(0, 4'b1000, 4'b0000, 4'b0000, "R6 unbounded still open");
      step(0, 4'b0000, 4'b0001, 4'b0000, "R5 release buffered");
      step(0, 4'b0001, 4'b0000, 4'b0000, "R2 open after release");
      step(0, 4'b0000, 4'b0000, 4'b0000, "R5 count after release");
      repeat (2) @(negedge clk);
      #3;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(8 * 200000);
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule